// File: doc/BRIEF.md
# Data Slice Loopback Self-Test Checker

This block is a built-in self-test for one data slice of a memory interface. A 16-bit linear feedback shift register (LFSR) produces pseudo-random write data. That data leaves through the slice's write multiplexer, comes back through a registered loopback return path with a fixed latency of `RET_LAT` cycles, and is compared against a copy of the LFSR output. The copy is delayed by a programmable alignment stage. Any mismatch sets a sticky error flag.

A two-bit mode input sequences the test: idle (functional traffic), write (generate, return and compare), stop (freeze everything so the flag and the pipelines can be inspected) and clear (return the generator, pipelines, fill counter and flag to their start values). An observation output shows either the expected or the returned data. When a push bit is set, the returned data can also be placed on the read-data path toward the controller.

The mode input is decoded the same cycle into one of five phases. PH_IDLE is mode 2'b00. PH_PRIME is mode 2'b01 while the pipelines are still filling. PH_COMPARE is mode 2'b01 once the fill count is reached. PH_FROZEN is mode 2'b10. PH_WIPE is mode 2'b11. Any phase can move to any other on a mode change. PH_PRIME moves to PH_COMPARE when the fill counter reaches its threshold.

Top module: `slice_lbk_bist`

## Requirements
- R1: After reset the error flag is 0, the generator holds the seed 16'hACE1, and every stage of both pipelines is 0, so `obs_data` reads 0 for either `obs_pick`.
- R2: `lb_mode` is decoded in the same cycle: 2'b00 idle, 2'b01 write, 2'b10 stop, 2'b11 clear.
- R3: In write mode the generator steps once per clock as a left shift that takes in bit15^bit13^bit12^bit10 (x^16+x^14+x^13+x^11+1). It does not step in any other mode. With `wr_src_lfsr`=1, `pad_wdata` shows the current generator value.
- R4: In idle mode `pad_wdata` equals `func_wdata` and `ctl_rdata` equals `func_rdata`, whatever the values of the select bits.
- R5: The return path delays `pad_wdata` by `RET_LAT` (3) write-mode cycles. `obs_pick`=1 shows this returned data.
- R6: `obs_pick`=0 shows the generator value delayed by `chk_dly`+1 write-mode cycles, for codes 0 to 6.
- R7: No comparison is made until the number of write-mode cycles since clear reaches max(`RET_LAT`, `chk_dly`+1), so stale pipeline contents never raise the flag.
- R8: A mismatch in a comparing cycle sets `err_sticky` at the next clock edge. It stays set through write, stop and idle modes until clear mode is applied.
- R9: Stop mode freezes the generator, both pipelines, the fill counter and the flag. A later return to write mode continues with the alignment unchanged.
- R10: One cycle of clear mode restores the state described in R1.
- R11: `chk_dly` code 3'd7 is illegal and forces a pass: the flag never sets while it is applied, whatever the data.
- R12: Outside idle mode, `ctl_rdata` shows the returned data when `rd_push`=1 and `rd_src_lbk`=1. Otherwise it shows `func_rdata`.
- R13: In write mode with `wr_src_lfsr`=0, `pad_wdata` carries `func_wdata`, and that data is what gets returned and compared.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| lb_mode | input | 2 | Test mode: 00 idle, 01 write, 10 stop, 11 clear |
| chk_dly | input | 3 | Alignment delay code, 0 to 6; 7 is illegal |
| obs_pick | input | 1 | Observation select: 0 expected, 1 returned |
| rd_push | input | 1 | Push returned data onto the read path |
| wr_src_lfsr | input | 1 | Write multiplexer: 1 generator data, 0 functional data |
| rd_src_lbk | input | 1 | Read multiplexer: 1 loopback data, 0 functional data |
| func_wdata | input | 16 | Functional write data |
| func_rdata | input | 16 | Functional read data |
| pad_wdata | output | 16 | Data sent toward the pads |
| ctl_rdata | output | 16 | Read data toward the controller |
| obs_data | output | 16 | Observation output |
| err_sticky | output | 1 | Sticky mismatch flag |

## Verification
`pad_wdata` and `ctl_rdata` follow the mode and select inputs in the same cycle. The bench therefore reads them 1 ns after changing the inputs at a falling edge. `obs_data` changes one edge after each write-mode step. After k write-mode edges, expected data equals generator state k-1-`chk_dly` and returned data equals state k-3, both taken from an LFSR sequence computed in the bench. The error flag rises on edge max(3, `chk_dly`+1)+1 after write mode begins. The bench checks that it is still low one edge earlier and high exactly then, for two delay codes. All other checks are sampled at falling edges, half a period away from the active edge.

// File: rtl/slice_lbk_pkg.sv
package slice_lbk_pkg;

    typedef enum logic [1:0] {
        LM_IDLE  = 2'b00,
        LM_WRITE = 2'b01,
        LM_STOP  = 2'b10,
        LM_CLEAR = 2'b11
    } lbk_mode_e;

    typedef enum logic [2:0] {
        PH_IDLE,
        PH_PRIME,
        PH_COMPARE,
        PH_FROZEN,
        PH_WIPE
    } lbk_phase_e;

endpackage

// File: rtl/lbk_lfsr.sv
module lbk_lfsr #(
    parameter int               WIDTH = 16,
    parameter logic [WIDTH-1:0] SEED  = 16'hACE1,
    parameter logic [WIDTH-1:0] TAPS  = 16'hB400
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             step,
    input  logic             wipe,
    output logic [WIDTH-1:0] state
);

    logic [WIDTH-1:0] state_q;
    logic             fb;

    assign fb    = ^(state_q & TAPS);
    assign state = state_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= SEED;
        end else if (wipe) begin
            state_q <= SEED;
        end else if (step) begin
            state_q <= {state_q[WIDTH-2:0], fb};
        end
    end

    // R9: generator holds still when not stepping
    a_r9_lfsr_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (!step && !wipe) |=> $stable(state_q));

    // R10: clear returns the seed
    a_r10_lfsr_seed: assert property (@(posedge clk) disable iff (!rst_n)
        wipe |=> (state_q == SEED));

    // R3: a nonzero seed never reaches the lock-up state
    a_r3_lfsr_nonzero: assert property (@(posedge clk) disable iff (!rst_n)
        state_q != '0);

endmodule

// File: rtl/lbk_delay_line.sv
module lbk_delay_line #(
    parameter int WIDTH = 16,
    parameter int DEPTH = 7,
    parameter int SEL_W = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             shift,
    input  logic             wipe,
    input  logic [WIDTH-1:0] din,
    input  logic [SEL_W-1:0] sel,
    output logic [WIDTH-1:0] dout
);

    logic [WIDTH-1:0] stg [DEPTH];

    for (genvar g = 0; g < DEPTH; g++) begin : g_stage
        logic [WIDTH-1:0] src;
        if (g == 0) begin : g_head
            assign src = din;
        end else begin : g_body
            assign src = stg[g-1];
        end
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                stg[g] <= '0;
            end else if (wipe) begin
                stg[g] <= '0;
            end else if (shift) begin
                stg[g] <= src;
            end
        end
    end

    // Out-of-range selections read the deepest stage.
    always_comb begin
        dout = stg[DEPTH-1];
        for (int i = 0; i < DEPTH; i++) begin
            if (sel == SEL_W'(i)) begin
                dout = stg[i];
            end
        end
    end

    // R5: the head stage captures the input on each shift
    a_r5_head_capture: assert property (@(posedge clk) disable iff (!rst_n)
        (shift && !wipe) |=> (stg[0] == $past(din)));

endmodule

// File: rtl/slice_lbk_bist.sv
module slice_lbk_bist
    import slice_lbk_pkg::*;
#(
    parameter int                DATA_W    = 16,
    parameter int                DLY_W     = 3,
    parameter int                RET_LAT   = 3,
    parameter logic [DATA_W-1:0] LFSR_SEED = 16'hACE1,
    parameter logic [DATA_W-1:0] LFSR_TAPS = 16'hB400
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [1:0]        lb_mode,
    input  logic [DLY_W-1:0]  chk_dly,
    input  logic              obs_pick,
    input  logic              rd_push,
    input  logic              wr_src_lfsr,
    input  logic              rd_src_lbk,
    input  logic [DATA_W-1:0] func_wdata,
    input  logic [DATA_W-1:0] func_rdata,
    output logic [DATA_W-1:0] pad_wdata,
    output logic [DATA_W-1:0] ctl_rdata,
    output logic [DATA_W-1:0] obs_data,
    output logic              err_sticky
);

    localparam int               DLY_STAGES = (1 << DLY_W) - 1;
    localparam logic [DLY_W-1:0] DLY_BAD    = '1;
    localparam int               NEED_MAX   = (RET_LAT > DLY_STAGES + 1) ? RET_LAT : DLY_STAGES + 1;
    localparam int               CNT_W      = $clog2(NEED_MAX + 1);
    localparam int               RET_SEL_W  = $clog2(RET_LAT + 1);
    localparam logic [RET_SEL_W-1:0] RET_TAP = RET_SEL_W'(RET_LAT - 1);

    lbk_mode_e   mode_e;
    lbk_phase_e  ph_cur, ph_q;

    logic              step, wipe, chk_en, drive_lfsr, drive_lbk;
    logic [DATA_W-1:0] gen_q, act_d, exp_d;
    logic [CNT_W-1:0]  cnt_q, need_c;
    logic              fill_ok, bad_code, mismatch, err_q;

    assign mode_e = lbk_mode_e'(lb_mode);

    // Fill threshold: both pipelines must hold write-mode data.
    always_comb begin
        if (CNT_W'(chk_dly) + CNT_W'(1) > CNT_W'(RET_LAT)) begin
            need_c = CNT_W'(chk_dly) + CNT_W'(1);
        end else begin
            need_c = CNT_W'(RET_LAT);
        end
    end
    assign fill_ok = (cnt_q >= need_c);

    // Phase decode
    always_comb begin
        unique case (mode_e)
            LM_IDLE:  ph_cur = PH_IDLE;
            LM_WRITE: ph_cur = fill_ok ? PH_COMPARE : PH_PRIME;
            LM_STOP:  ph_cur = PH_FROZEN;
            LM_CLEAR: ph_cur = PH_WIPE;
        endcase
    end

    // Phase register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ph_q <= PH_IDLE;
        end else begin
            ph_q <= ph_cur;
        end
    end

    // Phase outputs
    always_comb begin
        step       = 1'b0;
        wipe       = 1'b0;
        chk_en     = 1'b0;
        drive_lfsr = 1'b0;
        drive_lbk  = 1'b0;
        unique case (ph_cur)
            PH_IDLE: begin
            end
            PH_PRIME: begin
                step       = 1'b1;
                drive_lfsr = wr_src_lfsr;
                drive_lbk  = rd_src_lbk && rd_push;
            end
            PH_COMPARE: begin
                step       = 1'b1;
                chk_en     = 1'b1;
                drive_lfsr = wr_src_lfsr;
                drive_lbk  = rd_src_lbk && rd_push;
            end
            PH_FROZEN: begin
                drive_lbk  = rd_src_lbk && rd_push;
            end
            PH_WIPE: begin
                wipe       = 1'b1;
                drive_lbk  = rd_src_lbk && rd_push;
            end
            default: begin
            end
        endcase
    end

    lbk_lfsr #(
        .WIDTH (DATA_W),
        .SEED  (LFSR_SEED),
        .TAPS  (LFSR_TAPS)
    ) u_gen (
        .clk   (clk),
        .rst_n (rst_n),
        .step  (step),
        .wipe  (wipe),
        .state (gen_q)
    );

    assign pad_wdata = drive_lfsr ? gen_q : func_wdata;

    // Loopback return path
    lbk_delay_line #(
        .WIDTH (DATA_W),
        .DEPTH (RET_LAT),
        .SEL_W (RET_SEL_W)
    ) u_ret (
        .clk   (clk),
        .rst_n (rst_n),
        .shift (step),
        .wipe  (wipe),
        .din   (pad_wdata),
        .sel   (RET_TAP),
        .dout  (act_d)
    );

    // Expected-data alignment pipeline
    lbk_delay_line #(
        .WIDTH (DATA_W),
        .DEPTH (DLY_STAGES),
        .SEL_W (DLY_W)
    ) u_exp (
        .clk   (clk),
        .rst_n (rst_n),
        .shift (step),
        .wipe  (wipe),
        .din   (gen_q),
        .sel   (chk_dly),
        .dout  (exp_d)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (wipe) begin
            cnt_q <= '0;
        end else if (step && cnt_q != CNT_W'(NEED_MAX)) begin
            cnt_q <= cnt_q + CNT_W'(1);
        end
    end

    assign bad_code = (chk_dly == DLY_BAD);
    assign mismatch = (act_d != exp_d);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            err_q <= 1'b0;
        end else if (wipe) begin
            err_q <= 1'b0;
        end else if (chk_en && mismatch && !bad_code) begin
            err_q <= 1'b1;
        end
    end

    assign err_sticky = err_q;
    assign obs_data   = obs_pick ? act_d : exp_d;
    assign ctl_rdata  = drive_lbk ? act_d : func_rdata;

    // R8: flag stays set until clear mode
    a_r8_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        (err_q && mode_e != LM_CLEAR) |=> err_q);

    // R11: illegal delay code never raises the flag
    a_r11_false_pass: assert property (@(posedge clk) disable iff (!rst_n)
        (bad_code && !err_q) |=> !err_q);

    // R7: no error before the pipelines have filled
    a_r7_no_early_error: assert property (@(posedge clk) disable iff (!rst_n)
        (!err_q && !fill_ok) |=> !err_q);

    // R10: a wipe phase leaves the fill counter at zero
    a_r10_wipe_count: assert property (@(posedge clk) disable iff (!rst_n)
        (ph_q == PH_WIPE) |-> (cnt_q == '0));

    // R4: idle mode passes functional data
    a_r4_idle_pass: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_e == LM_IDLE) |-> (pad_wdata == func_wdata && ctl_rdata == func_rdata));

endmodule

// File: tb/tb_slice_lbk_bist.sv
`timescale 1ns/1ps
module tb_slice_lbk_bist;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [1:0]  lb_mode = 2'b00;
    logic [2:0]  chk_dly = 3'd2;
    logic        obs_pick = 1'b0;
    logic        rd_push = 1'b0;
    logic        wr_src_lfsr = 1'b0;
    logic        rd_src_lbk = 1'b0;
    logic [15:0] func_wdata = '0;
    logic [15:0] func_rdata = '0;
    logic [15:0] pad_wdata, ctl_rdata, obs_data;
    logic        err_sticky;

    int n_chk = 0;
    int n_err = 0;
    logic [15:0] L [0:127];

    always #4 clk = ~clk;  // 125 MHz

    slice_lbk_bist dut (
        .clk         (clk),
        .rst_n       (rst_n),
        .lb_mode     (lb_mode),
        .chk_dly     (chk_dly),
        .obs_pick    (obs_pick),
        .rd_push     (rd_push),
        .wr_src_lfsr (wr_src_lfsr),
        .rd_src_lbk  (rd_src_lbk),
        .func_wdata  (func_wdata),
        .func_rdata  (func_rdata),
        .pad_wdata   (pad_wdata),
        .ctl_rdata   (ctl_rdata),
        .obs_data    (obs_data),
        .err_sticky  (err_sticky)
    );

    task automatic chk(input string tag, input logic [15:0] act, input logic [15:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic cyc();
        @(negedge clk);
    endtask

    task automatic do_clear();
        lb_mode = 2'b11;
        cyc();
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_chk++;
        n_err++;
        $display("FAIL watchdog actual=running expected=done");
        $display("  Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end

    initial begin
        L[0] = 16'hACE1;
        for (int i = 1; i < 128; i++) begin
            L[i] = {L[i-1][14:0], L[i-1][15] ^ L[i-1][13] ^ L[i-1][12] ^ L[i-1][10]};
        end

        repeat (3) cyc();
        rst_n = 1'b1;
        cyc();

        // R1: reset state
        chk("R1 err after reset", {15'd0, err_sticky}, 16'd0);
        obs_pick = 1'b0; #1;
        chk("R1 expected pipe after reset", obs_data, 16'd0);
        obs_pick = 1'b1; #1;
        chk("R1 return pipe after reset", obs_data, 16'd0);

        // R4: idle passthrough with all selects set
        wr_src_lfsr = 1'b1; rd_src_lbk = 1'b1; rd_push = 1'b1;
        func_wdata = 16'h1234; func_rdata = 16'h5678; #1;
        chk("R4 idle write path", pad_wdata, 16'h1234);
        chk("R4 idle read path", ctl_rdata, 16'h5678);
        repeat (3) cyc();
        // R3: no stepping in idle
        lb_mode = 2'b01; #1;
        chk("R3 seed held through idle", pad_wdata, L[0]);

        // Scenario A: aligned delay code 2
        chk_dly = 3'd2;
        do_clear();
        lb_mode = 2'b01; #1;
        chk("R10 seed after clear", pad_wdata, L[0]);
        for (int k = 1; k <= 30; k++) begin
            cyc();
            obs_pick = 1'b0; #1;
            chk("R3 sequence", pad_wdata, L[k]);
            chk("R7 R8 aligned no error", {15'd0, err_sticky}, 16'd0);
            if (k >= 7) begin
                chk("R6 expected tap d=2", obs_data, L[k-3]);
                obs_pick = 1'b1; #1;
                chk("R5 returned data", obs_data, L[k-3]);
                chk("R12 pushed read data", ctl_rdata, L[k-3]);
            end
        end

        // R9 / R2: stop freezes
        lb_mode = 2'b10; obs_pick = 1'b0; #1;
        chk("R2 stop write path functional", pad_wdata, 16'h1234);
        repeat (5) cyc();
        chk("R9 expected frozen", obs_data, L[27]);
        lb_mode = 2'b01; #1;
        chk("R9 generator frozen", pad_wdata, L[30]);
        for (int k = 31; k <= 40; k++) begin
            cyc();
            chk("R9 resume aligned", {15'd0, err_sticky}, 16'd0);
        end
        #1;
        chk("R3 after resume", pad_wdata, L[40]);

        // R12 select combinations
        rd_push = 1'b0; #1;
        chk("R12 push off", ctl_rdata, 16'h5678);
        rd_push = 1'b1; rd_src_lbk = 1'b0; #1;
        chk("R12 read mux functional", ctl_rdata, 16'h5678);
        rd_src_lbk = 1'b1;

        // R6: tap sweep while stopped
        lb_mode = 2'b10;
        obs_pick = 1'b0;
        for (int d = 0; d < 7; d++) begin
            chk_dly = 3'(d); #1;
            chk("R6 tap sweep", obs_data, L[39-d]);
        end

        // R13: functional data in write mode
        lb_mode = 2'b01; wr_src_lfsr = 1'b0; #1;
        chk("R13 write mux functional", pad_wdata, 16'h1234);
        wr_src_lfsr = 1'b1;

        // Delay code sweep: only code 2 aligns, 7 false-passes (R11)
        for (int d = 0; d < 8; d++) begin
            chk_dly = 3'(d);
            do_clear();
            lb_mode = 2'b01;
            repeat (20) cyc();
            chk((d == 7) ? "R11 code 7 pass" : "R8 delay sweep",
                {15'd0, err_sticky}, (d != 7 && d != 2) ? 16'd1 : 16'd0);
        end

        // R11: code 7 with garbage data
        chk_dly = 3'd7;
        do_clear();
        lb_mode = 2'b01; wr_src_lfsr = 1'b0; func_wdata = 16'h0000;
        repeat (20) cyc();
        chk("R11 code 7 garbage", {15'd0, err_sticky}, 16'd0);

        // R7 / R8: exact rise edge for d=2 (need 3) and d=5 (need 6)
        chk_dly = 3'd2;
        do_clear();
        lb_mode = 2'b01;
        repeat (3) cyc();
        chk("R7 no error before fill d=2", {15'd0, err_sticky}, 16'd0);
        cyc();
        chk("R8 error on first compare d=2", {15'd0, err_sticky}, 16'd1);

        chk_dly = 3'd5;
        do_clear();
        lb_mode = 2'b01;
        repeat (6) cyc();
        chk("R7 no error before fill d=5", {15'd0, err_sticky}, 16'd0);
        cyc();
        chk("R8 error on first compare d=5", {15'd0, err_sticky}, 16'd1);

        // R8 sticky through write, stop, idle
        wr_src_lfsr = 1'b1; chk_dly = 3'd2;
        repeat (20) cyc();
        chk("R8 sticky in write", {15'd0, err_sticky}, 16'd1);
        lb_mode = 2'b10;
        repeat (5) cyc();
        chk("R8 R9 sticky in stop", {15'd0, err_sticky}, 16'd1);
        lb_mode = 2'b00;
        repeat (3) cyc();
        chk("R8 sticky in idle", {15'd0, err_sticky}, 16'd1);

        // R10: clear
        do_clear();
        chk("R10 flag cleared", {15'd0, err_sticky}, 16'd0);
        obs_pick = 1'b0; #1;
        chk("R10 expected pipe cleared", obs_data, 16'd0);
        obs_pick = 1'b1; #1;
        chk("R10 return pipe cleared", obs_data, 16'd0);
        lb_mode = 2'b01; #1;
        chk("R10 seed restored", pad_wdata, L[0]);
        lb_mode = 2'b00;
        cyc();

        $display("  Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end

endmodule